// File: doc/BRIEF.md
# Opcode Fetch Cycle Sequencer with Memory Refresh

This block produces the bus activity of one instruction-fetch machine cycle of an 8-bit processor. The cycle lasts four clocks, T1 to T4. In the first half of the cycle the block presents the captured program counter on the address bus, marks the cycle as a fetch, and requests a memory read. At the rising edge that begins T3 it captures the opcode from the data bus. It then spends T3 and T4 on a refresh access for dynamic memory. During that access it places the interrupt-vector byte on the upper address lines and the refresh counter on the lower lines.

The refresh counter advances once per completed fetch, but only its low seven bits count. The top bit keeps whatever value was last written. A host writes either register through a simple write strobe. The host learns about a fetch through two pulses: one tells it when to advance its program counter, and one marks the end of the cycle. A new fetch can be requested on the edge that leaves T4, so fetches can run back to back. Decoding and executing the opcode are left to other logic.

Top module: `fetch_refresh_cycle`

## Requirements
- R1: While reset is held, and whenever no cycle is running, m1_n_o, mreq_n_o, rd_n_o and rfsh_n_o are high and done_o and pc_inc_o are low; reset clears the refresh and vector registers to 0x00.
- R2: A cycle starts when start_i is high at a rising edge while idle or in T4. During T1 and T2, addr_o equals the pc_i value sampled at that edge, and later changes of pc_i have no effect on it. m1_n_o is low exactly during T1 and T2.
- R3: mreq_n_o and rd_n_o are high in the first half of T1. They go low at the falling edge inside T1, stay low through T2, and return high at the rising edge that begins T3.
- R4: opcode_o takes the value of data_i sampled at the rising edge that begins T3 and holds it until the next such edge; data_i at any other edge has no effect.
- R5: During T3 and T4, addr_o[15:8] is the vector register and addr_o[7:0] is the refresh register, and rfsh_n_o is low for both full clocks.
- R6: In the refresh phase, mreq_n_o goes low at the falling edge inside T3 and high at the falling edge inside T4. rd_n_o stays high throughout T3 and T4.
- R7: At the rising edge that leaves T4, bits 6:0 of the refresh register increment modulo 128 and bit 7 is unchanged (0x7F becomes 0x00, 0xFF becomes 0x80).
- R8: r_wr_i loads wdata_i into the refresh register and i_wr_i loads it into the vector register at the next rising edge. A refresh write at the edge that leaves T4 takes precedence over the increment.
- R9: pc_inc_o is high for exactly the T3 clock, and done_o is high for exactly the one clock that follows T4.
- R10: start_i is ignored during T1, T2 and T3. If start_i is high at the edge leaving T4, the next clock is T1 of a new cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a fetch cycle |
| pc_i | input | 16 | Program counter value, sampled at cycle start |
| data_i | input | 8 | Data bus in |
| r_wr_i | input | 1 | Load refresh register from wdata_i |
| i_wr_i | input | 1 | Load vector register from wdata_i |
| wdata_i | input | 8 | Register write data |
| addr_o | output | 16 | Address bus |
| m1_n_o | output | 1 | Fetch indicator, active low |
| mreq_n_o | output | 1 | Memory request, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| rfsh_n_o | output | 1 | Refresh strobe, active low |
| opcode_o | output | 8 | Latched opcode |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| pc_inc_o | output | 1 | One-clock request to advance the program counter |
| r_o | output | 8 | Refresh register value |
| i_o | output | 8 | Vector register value |

## Verification
Two situations are hard to reach from the ports. The first is a refresh-register write that lands on the same edge as the end-of-cycle increment. The stimulus reaches it by raising r_wr_i during T4 of randomly chosen fetches. The second is a back-to-back fetch, where start_i is held at the T4 edge so that T1 follows with no idle clock; the random loop picks this often. Each strobe is sampled in both halves of every clock state, because mreq_n_o and rd_n_o change on falling edges. The wrap of the seven-bit counter is set up directly by writing 0x7F and 0xFF before a fetch.

// File: rtl/fetch_refresh_pkg.sv
package fetch_refresh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_T4   = 3'd4
  } fc_state_e;
endpackage

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_refresh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] data_i,
  output fc_state_e         state_o,
  output logic [ADDR_W-1:0] pc_q_o,
  output logic [DATA_W-1:0] opcode_o,
  output logic              done_o,
  output logic              end_cyc_o
);
  fc_state_e state_q, state_d;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] op_q;
  logic done_q;
  logic may_start;

  assign may_start = (state_q == ST_IDLE) || (state_q == ST_T4);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = start_i ? ST_T1 : ST_IDLE;
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3:   state_d = ST_T4;
      ST_T4:   state_d = start_i ? ST_T1 : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      op_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_T4);
      if (may_start && start_i) pc_q <= pc_i;
      // opcode sampled on the edge that enters T3
      if (state_q == ST_T2) op_q <= data_i;
    end
  end

  assign state_o   = state_q;
  assign pc_q_o    = pc_q;
  assign opcode_o  = op_q;
  assign done_o    = done_q;
  assign end_cyc_o = (state_q == ST_T4);
endmodule

// File: rtl/fetch_strobes.sv
module fetch_strobes
  import fetch_refresh_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  fc_state_e state_i,
  output logic      m1_n_o,
  output logic      mreq_n_o,
  output logic      rd_n_o,
  output logic      rfsh_n_o,
  output logic      pc_inc_o
);
  logic fetch_ph, rfsh_ph;
  logic fetch_arm_q, rf_arm_q;

  assign fetch_ph = (state_i == ST_T1) || (state_i == ST_T2);
  assign rfsh_ph  = (state_i == ST_T3) || (state_i == ST_T4);

  // half-clock stages: armed on falling edges
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_arm_q <= 1'b0;
      rf_arm_q    <= 1'b0;
    end else begin
      fetch_arm_q <= fetch_ph;
      rf_arm_q    <= (state_i == ST_T3);
    end
  end

  // fetch strobes cut off by the rising edge entering T3
  assign rd_n_o   = ~(fetch_arm_q & fetch_ph);
  assign mreq_n_o = ~((fetch_arm_q & fetch_ph) | rf_arm_q);
  assign m1_n_o   = ~fetch_ph;
  assign rfsh_n_o = ~rfsh_ph;
  assign pc_inc_o = (state_i == ST_T3);
endmodule

// File: rtl/refresh_regs.sv
module refresh_regs #(
  parameter int DATA_W = 8,
  parameter int RCNT_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              r_wr_i,
  input  logic              i_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bump_i,
  output logic [DATA_W-1:0] r_o,
  output logic [DATA_W-1:0] i_o
);
  logic [DATA_W-1:0] r_q, i_q, r_bump;

  generate
    if (RCNT_W < DATA_W) begin : g_partial
      assign r_bump = {r_q[DATA_W-1:RCNT_W], r_q[RCNT_W-1:0] + 1'b1};
    end else begin : g_full
      assign r_bump = r_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q <= '0;
      i_q <= '0;
    end else begin
      if (r_wr_i)      r_q <= wdata_i;
      else if (bump_i) r_q <= r_bump;
      if (i_wr_i)      i_q <= wdata_i;
    end
  end

  assign r_o = r_q;
  assign i_o = i_q;
endmodule

// File: rtl/fetch_refresh_cycle.sv
module fetch_refresh_cycle
  import fetch_refresh_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RCNT_W = DATA_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2*DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                r_wr_i,
  input  logic                i_wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [2*DATA_W-1:0] addr_o,
  output logic                m1_n_o,
  output logic                mreq_n_o,
  output logic                rd_n_o,
  output logic                rfsh_n_o,
  output logic [DATA_W-1:0]   opcode_o,
  output logic                done_o,
  output logic                pc_inc_o,
  output logic [DATA_W-1:0]   r_o,
  output logic [DATA_W-1:0]   i_o
);
  localparam int ADDR_W = 2 * DATA_W;

  fc_state_e state;
  logic [ADDR_W-1:0] pc_q;
  logic end_cyc;
  logic rfsh_n;

  fetch_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .pc_i      (pc_i),
    .data_i    (data_i),
    .state_o   (state),
    .pc_q_o    (pc_q),
    .opcode_o  (opcode_o),
    .done_o    (done_o),
    .end_cyc_o (end_cyc)
  );

  fetch_strobes u_strb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_i  (state),
    .m1_n_o   (m1_n_o),
    .mreq_n_o (mreq_n_o),
    .rd_n_o   (rd_n_o),
    .rfsh_n_o (rfsh_n),
    .pc_inc_o (pc_inc_o)
  );

  refresh_regs #(.DATA_W(DATA_W), .RCNT_W(RCNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .r_wr_i  (r_wr_i),
    .i_wr_i  (i_wr_i),
    .wdata_i (wdata_i),
    .bump_i  (end_cyc),
    .r_o     (r_o),
    .i_o     (i_o)
  );

  assign rfsh_n_o = rfsh_n;
  assign addr_o   = rfsh_n ? pc_q : {i_o, r_o};
endmodule

// File: rtl/fetch_refresh_chk.sv
module fetch_refresh_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                r_wr_i,
  input logic [2*DATA_W-1:0] addr_o,
  input logic                m1_n_o,
  input logic                mreq_n_o,
  input logic                rd_n_o,
  input logic                rfsh_n_o,
  input logic [DATA_W-1:0]   opcode_o,
  input logic                done_o,
  input logic                pc_inc_o,
  input logic [DATA_W-1:0]   r_o,
  input logic [DATA_W-1:0]   i_o
);
  AST_M1_NOT_IN_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m1_n_o |-> rfsh_n_o); // R2
  AST_OPCODE_ONLY_AT_T3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(opcode_o) |-> pc_inc_o); // R4
  AST_REFRESH_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_n_o |-> addr_o == {i_o, r_o}); // R5
  AST_NO_READ_IN_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rfsh_n_o |-> rd_n_o); // R6
  AST_R_TOP_BIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !r_wr_i |=> $stable(r_o[DATA_W-1])); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_PCINC_THEN_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_inc_o |=> !rfsh_n_o && !pc_inc_o); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_n_o && rfsh_n_o) |-> (rd_n_o && mreq_n_o)); // R1
endmodule

bind fetch_refresh_cycle fetch_refresh_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .r_wr_i   (r_wr_i),
  .addr_o   (addr_o),
  .m1_n_o   (m1_n_o),
  .mreq_n_o (mreq_n_o),
  .rd_n_o   (rd_n_o),
  .rfsh_n_o (rfsh_n_o),
  .opcode_o (opcode_o),
  .done_o   (done_o),
  .pc_inc_o (pc_inc_o),
  .r_o      (r_o),
  .i_o      (i_o)
);

// File: tb/sim_fetch_refresh_cycle.sv
`timescale 1ns/1ps
module sim_fetch_refresh_cycle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pc = '0;
  logic [7:0]  din = '0;
  logic        r_wr = 1'b0, i_wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [15:0] addr;
  logic        m1_n, mreq_n, rd_n, rfsh_n, done, pc_inc;
  logic [7:0]  opcode, r_v, i_v;

  int n_chk = 0, n_bad = 0;
  logic [7:0] r_m = '0, i_m = '0;

  always #10 clk = ~clk;

  fetch_refresh_cycle u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pc_i(pc), .data_i(din),
    .r_wr_i(r_wr), .i_wr_i(i_wr), .wdata_i(wdata), .addr_o(addr),
    .m1_n_o(m1_n), .mreq_n_o(mreq_n), .rd_n_o(rd_n), .rfsh_n_o(rfsh_n),
    .opcode_o(opcode), .done_o(done), .pc_inc_o(pc_inc), .r_o(r_v), .i_o(i_v)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] r_next(input logic [7:0] r);
    return {r[7], r[6:0] + 7'd1};
  endfunction

  // strobe vector {m1,mreq,rd,rfsh}
  function automatic logic [15:0] strb();
    return {12'd0, m1_n, mreq_n, rd_n, rfsh_n};
  endfunction

  task automatic idle_check();
    chk("R1", "idle strobes", strb(), 16'hF);
    chk("R1", "idle done", {15'd0, done}, 16'd0);
    chk("R1", "idle pc_inc", {15'd0, pc_inc}, 16'd0);
  endtask

  // entry: T1 at posedge+5; exit: following clock at posedge+5
  task automatic fetch(input logic [15:0] pcv, input logic [7:0] op,
                       input bit b2b, input bit col, input logic [7:0] wv);
    chk("R2", "T1a addr", addr, pcv);
    chk("R3", "T1a strobes", strb(), 16'h7);
    pc = 16'($urandom); din = 8'($urandom); start = 1'($urandom);
    #10;
    chk("R3", "T1b strobes", strb(), 16'h1);
    chk("R2", "T1b addr", addr, pcv);
    @(posedge clk); #5;
    chk("R2", "T2a addr", addr, pcv);
    chk("R3", "T2a strobes", strb(), 16'h1);
    din = op;
    #10;
    chk("R3", "T2b strobes", strb(), 16'h1);
    @(posedge clk); #5;
    din = 8'($urandom); start = 1'($urandom);
    chk("R4", "T3 opcode", {8'd0, opcode}, {8'd0, op});
    chk("R5", "T3 addr", addr, {i_m, r_m});
    chk("R6", "T3a strobes", strb(), 16'hE);
    chk("R9", "T3 pc_inc", {15'd0, pc_inc}, 16'd1);
    #10;
    chk("R6", "T3b strobes", strb(), 16'hA);
    @(posedge clk); #5;
    chk("R10", "T4 reached", {15'd0, rfsh_n}, 16'd0);
    chk("R5", "T4 addr", addr, {i_m, r_m});
    chk("R6", "T4a strobes", strb(), 16'hA);
    chk("R9", "T4 pc_inc", {15'd0, pc_inc}, 16'd0);
    start = b2b;
    if (b2b) pc = pcv + 16'd1;
    if (col) begin r_wr = 1'b1; wdata = wv; end
    #10;
    chk("R6", "T4b strobes", strb(), 16'hE);
    @(posedge clk); #5;
    r_wr = 1'b0; start = 1'b0;
    r_m = col ? wv : r_next(r_m);
    chk(col ? "R8" : "R7", "r after fetch", {8'd0, r_v}, {8'd0, r_m});
    chk("R9", "done pulse", {15'd0, done}, 16'd1);
    chk("R4", "opcode held", {8'd0, opcode}, {8'd0, op});
    chk("R10", "next m1", {15'd0, m1_n}, {15'd0, !b2b});
  endtask

  task automatic idle_write(input bit to_r, input logic [7:0] v);
    if (to_r) r_wr = 1'b1; else i_wr = 1'b1;
    wdata = v;
    @(posedge clk); #5;
    r_wr = 1'b0; i_wr = 1'b0;
    if (to_r) r_m = v; else i_m = v;
    chk("R8", "reg write", {r_v, i_v}, {r_m, i_m});
    idle_check();
    chk("R9", "done after idle", {15'd0, done}, 16'd0);
  endtask

  task automatic launch(input logic [15:0] pcv);
    start = 1'b1; pc = pcv;
    @(posedge clk); #5;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1729));
    @(posedge clk); #5;
    idle_check();
    chk("R1", "reset regs", {r_v, i_v}, 16'h0000);
    @(posedge clk); #5;
    rst_n = 1'b1;
    @(posedge clk); #5;
    idle_check();

    // directed: plain fetch
    launch(16'h1234); fetch(16'h1234, 8'h3E, 1'b0, 1'b0, 8'h00);
    @(posedge clk); #5; idle_check();
    // R7 wrap cases
    idle_write(1'b1, 8'h7F); idle_write(1'b0, 8'hA5);
    launch(16'h0100); fetch(16'h0100, 8'h00, 1'b0, 1'b0, 8'h00);
    chk("R7", "wrap 7F", {8'd0, r_v}, 16'h0000);
    idle_write(1'b1, 8'hFF);
    launch(16'hFFFF); fetch(16'hFFFF, 8'hC9, 1'b0, 1'b0, 8'h00);
    chk("R7", "wrap FF", {8'd0, r_v}, 16'h0080);
    // R8 collision with increment, back-to-back R10
    launch(16'h2000); fetch(16'h2000, 8'h11, 1'b1, 1'b1, 8'h42);
    fetch(16'h2001, 8'h22, 1'b0, 1'b0, 8'h00);

    // random
    for (int k = 0; k < 60; k++) begin
      logic [15:0] pcv;
      bit b2b;
      pcv = 16'($urandom);
      launch(pcv);
      do begin
        b2b = ($urandom % 3) == 0;
        fetch(pcv, 8'($urandom), b2b, ($urandom % 5) == 0, 8'($urandom));
        pcv = pcv + 16'd1;
      end while (b2b);
      for (int j = 0; j < int'($urandom % 3); j++) begin
        if ($urandom % 2) idle_write(1'($urandom), 8'($urandom));
        else begin
          din = 8'($urandom);
          @(posedge clk); #5;
          idle_check();
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule